// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is an 8-bit interval timer that sits on the register bus of a small microcontroller. Software sees two byte registers. The first is a count register that software can write and read back. The second is a control register that holds the rate select, an interrupt mask, a sticky timeout flag and a prescaler-preset command. The system clock is divided by four to form a base tick. A free-running 7-bit prescaler counts these base ticks. The control register chooses how many prescaler steps make one decrement of the count.

When a decrement brings the count to zero, the timeout flag is set. If the mask is clear, an active-high interrupt level is also raised. This level stays high until the core acknowledges it or software rewrites the control register. A control write re-evaluates the interrupt from the flag and mask values it leaves behind.

Three small state machines make up the block:
- A phase generator cycles through the states `PH_0`, `PH_1`, `PH_2` and `PH_3`. Each transition is unconditional, and the tick is asserted in `PH_3`.
- The prescaler holds a count register and chooses a rate variant through generate.
- An interrupt machine has two states, `IRQ_IDLE` and `IRQ_PEND`. It makes the transition IDLE→PEND on an unmasked timeout, or on a control write that leaves the flag set and the mask clear. It makes the transition PEND→IDLE on an acknowledge, or on a control write that leaves no request.

Top module: `itmr_top`

## Requirements
- R1: After reset the count register reads 0x00, the control register reads 0x00 and `irq` is 0.
- R2: A base tick occurs once every 4 system clocks. With the rate select (control bits [2:0]) at 0, the count decrements by one on every base tick.
- R3: With a rate select of n from 1 to 7, let r(p) = ((p >> (n-1)) + 1) >> 1, where p is the prescaler value unwrapped. The count decrements on a base tick when r(prescaler+1) differs from r(prescaler). In steady state this is one decrement every 2^n base ticks. The prescaler is 7 bits wide and wraps from 0x7F to 0x00.
- R4: Bus select 0 addresses the count register. A write stores the byte, and a read returns the current count. A decrement from 0x00 wraps to 0xFF and does not set the timeout flag.
- R5: When a decrement makes the count 0x00, control bit 7 (the timeout flag) is set. It stays set until software clears it.
- R6: A timeout raises `irq` only when control bit 6 (the mask) is 0. With the mask set, the flag is still set but `irq` stays low.
- R7: After any control write (bus select 1), `irq` is 1 exactly when the resulting bits [7:6] are 2'b10. Otherwise `irq` is 0.
- R8: A control write with bit 7 at 0 clears the timeout flag. A write with bit 7 at 1 leaves the flag unchanged and never sets it.
- R9: A control write with bit 3 at 1 loads the prescaler with 0x7F. Bit 3 always reads back as 0.
- R10: Once raised, `irq` stays high until `irq_ack` is pulsed or a control write clears it. The acknowledge does not clear the timeout flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register select: 0 = count, 1 = control |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Active-high interrupt request level |

## Verification
The bench measures the spacing between count changes at several rate selects. A design with the wrong rounding or the wrong divide shows intervals other than 4, 8, 32 or 128 clocks. The bench also measures the delay from a preset command to the first decrement. A prescaler that is not loaded with 0x7F misses the window of 17 to 20 clocks, which only that value produces. The bench drives the count through 0x00 into 0xFF with the flag cleared, so a design that flags a wrap gets caught. Finally, it walks the control-write cases for flag and mask, along with the acknowledge. A design that sets the flag on a write of 1, that lets the mask leak into a timeout, or that drops the request on its own shows the wrong `irq` or readback.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    // Control register field positions (the interrupt logic decodes these)
    localparam int unsigned FLAG_BIT   = 7;
    localparam int unsigned MASK_BIT   = 6;
    localparam int unsigned PRESET_BIT = 3;

    // Bus register select
    localparam logic SEL_COUNT = 1'b0;
    localparam logic SEL_CTRL  = 1'b1;

    // Base tick phase: system clock divided by four
    typedef enum logic [1:0] {
        PH_0 = 2'd0,
        PH_1 = 2'd1,
        PH_2 = 2'd2,
        PH_3 = 2'd3
    } phase_e;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_e;

endpackage

// File: rtl/itmr_phase_gen.sv
module itmr_phase_gen
    import itmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    phase_e ph_q;
    phase_e ph_d;

    // Next state: unconditional ring of four phases
    always_comb begin
        unique case (ph_q)
            PH_0:    ph_d = PH_1;
            PH_1:    ph_d = PH_2;
            PH_2:    ph_d = PH_3;
            PH_3:    ph_d = PH_0;
            default: ph_d = PH_0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_0;
        else        ph_q <= ph_d;
    end

    // Output: one base tick per ring lap
    always_comb begin
        tick = (ph_q == PH_3);
    end

    // R2: ticks never come back to back
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
    parameter int unsigned PRE_W = 7,
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [SEL_W-1:0] sel,
    output logic [PRE_W-1:0] cnt,
    output logic             step
);

    localparam int unsigned NSEL  = 1 << SEL_W;
    localparam int unsigned EXT_W = PRE_W + 2;
    localparam logic [EXT_W-1:0] ONE = EXT_W'(1);

    logic [EXT_W-1:0] cur_x;
    logic [EXT_W-1:0] nxt_x;
    logic [NSEL-1:0]  adv;

    // Unwrapped view so the 0x7F -> 0x80 step is seen before the wrap
    assign cur_x = EXT_W'(cnt);
    assign nxt_x = cur_x + ONE;

    assign adv[0] = 1'b1;

    // One rounding comparator per rate select
    for (genvar g = 1; g < NSEL; g++) begin : g_rate
        localparam int unsigned SH = g - 1;
        logic [EXT_W-1:0] r_cur;
        logic [EXT_W-1:0] r_nxt;
        assign r_cur  = ((cur_x >> SH) + ONE) >> 1;
        assign r_nxt  = ((nxt_x >> SH) + ONE) >> 1;
        assign adv[g] = (r_cur != r_nxt);
    end

    assign step = tick & adv[sel];

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= '1;
        else if (tick) cnt <= cnt + 1'b1;
    end

    // R9: a preset command leaves the prescaler at all ones
    p_preset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == '1));

    // R3: the prescaler advances by one (with wrap) per base tick
    p_cnt_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load) |=> (cnt == PRE_W'($past(cnt) + 1'b1)));

    // R3: no movement without a tick or a preset
    p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt));

endmodule

// File: rtl/itmr_irq_fsm.sv
module itmr_irq_fsm
    import itmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic timeout,
    input  logic mask_cur,
    input  logic ctl_wr,
    input  logic wr_flag,
    input  logic wr_mask,
    input  logic ack,
    output logic irq
);

    irq_state_e st_q;
    irq_state_e st_d;

    // A control write takes priority, then an unmasked timeout, then the acknowledge
    always_comb begin
        unique case (st_q)
            IRQ_IDLE: begin
                if (ctl_wr)                    st_d = (wr_flag && !wr_mask) ? IRQ_PEND : IRQ_IDLE;
                else if (timeout && !mask_cur) st_d = IRQ_PEND;
                else                           st_d = IRQ_IDLE;
            end
            IRQ_PEND: begin
                if (ctl_wr)                    st_d = (wr_flag && !wr_mask) ? IRQ_PEND : IRQ_IDLE;
                else if (timeout && !mask_cur) st_d = IRQ_PEND;
                else if (ack)                  st_d = IRQ_IDLE;
                else                           st_d = IRQ_PEND;
            end
            default: st_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= IRQ_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        irq = (st_q == IRQ_PEND);
    end

    // R6: an unmasked timeout raises the request
    p_irq_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && !mask_cur && !ctl_wr) |=> irq);

    // R6: a masked timeout does not raise it
    p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && timeout && mask_cur && !ctl_wr) |=> !irq);

    // R10: the request holds until it is acknowledged or rewritten
    p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack && !ctl_wr) |=> irq);

    // R10: an acknowledge with nothing competing clears it
    p_irq_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !timeout && !ctl_wr) |=> !irq);

endmodule

// File: rtl/itmr_top.sv
module itmr_top
    import itmr_pkg::*;
#(
    parameter int unsigned DAT_W = 8,
    parameter int unsigned PRE_W = 7,
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [DAT_W-1:0] bus_wdata,
    output logic [DAT_W-1:0] bus_rdata,
    input  logic             irq_ack,
    output logic             irq
);

    localparam logic [DAT_W-1:0] CNT_ONE = DAT_W'(1);

    logic             tick;
    logic             step;
    logic [PRE_W-1:0] pre_cnt;
    logic [DAT_W-1:0] dat_q;
    logic [DAT_W-1:0] dat_d;
    logic [DAT_W-1:0] ctl_q;
    logic [DAT_W-1:0] ctl_d;
    logic             wr_dat;
    logic             wr_ctl;
    logic             timeout;
    logic             flag_cont;
    logic             preset;

    assign wr_dat  = bus_wr && (bus_sel == SEL_COUNT);
    assign wr_ctl  = bus_wr && (bus_sel == SEL_CTRL);
    assign preset  = wr_ctl && bus_wdata[PRESET_BIT];

    // A decrement that lands on zero (a bus write to the count wins)
    assign timeout   = step && !wr_dat && (dat_q == CNT_ONE);
    assign flag_cont = ctl_q[FLAG_BIT] | timeout;

    itmr_phase_gen u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    itmr_prescaler #(
        .PRE_W (PRE_W),
        .SEL_W (SEL_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .load  (preset),
        .sel   (ctl_q[SEL_W-1:0]),
        .cnt   (pre_cnt),
        .step  (step)
    );

    // Count register
    always_comb begin
        if (wr_dat)    dat_d = bus_wdata;
        else if (step) dat_d = dat_q - 1'b1;
        else           dat_d = dat_q;
    end

    // Control register: the flag can only be kept or cleared by a write; the preset bit self-clears
    always_comb begin
        ctl_d = ctl_q;
        ctl_d[FLAG_BIT] = flag_cont;
        if (wr_ctl) begin
            ctl_d = bus_wdata;
            ctl_d[FLAG_BIT]   = flag_cont & bus_wdata[FLAG_BIT];
            ctl_d[PRESET_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_q <= '0;
            ctl_q <= '0;
        end else begin
            dat_q <= dat_d;
            ctl_q <= ctl_d;
        end
    end

    itmr_irq_fsm u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .timeout  (timeout),
        .mask_cur (ctl_q[MASK_BIT]),
        .ctl_wr   (wr_ctl),
        .wr_flag  (ctl_d[FLAG_BIT]),
        .wr_mask  (ctl_d[MASK_BIT]),
        .ack      (irq_ack),
        .irq      (irq)
    );

    assign bus_rdata = (bus_sel == SEL_CTRL) ? ctl_q : dat_q;

    // R7: after a control write the request mirrors flag-set, mask-clear
    p_irq_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> (irq == (ctl_q[FLAG_BIT] && !ctl_q[MASK_BIT])));

    // R2: each prescaled step takes exactly one off the count
    p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_dat) |=> (dat_q == DAT_W'($past(dat_q) - 1'b1)));

    // R5: the flag rises only from a decrement of one to zero
    p_flag_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q[FLAG_BIT]) |-> ($past(dat_q) == CNT_ONE && $past(step) && !$past(wr_dat)));

    // R8: a control write with bit 7 low leaves the flag clear
    p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !bus_wdata[FLAG_BIT]) |=> !ctl_q[FLAG_BIT]);

endmodule

// File: tb/itmr_top_bench.sv
module itmr_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_ack = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    itmr_top u_itmr_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_ack   (irq_ack),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    // Write at the next rising edge; return at the falling edge after it
    task automatic wr(input logic s, input logic [7:0] d);
        @(negedge clk);
        bus_sel = s; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic rd(input logic s, output logic [7:0] v);
        bus_sel = s;
        #1;
        v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Clocks until the count register changes
    task automatic wait_change(output int c);
        logic [7:0] prev;
        logic [7:0] v;
        rd(1'b0, prev);
        c = 0;
        forever begin
            @(negedge clk);
            c++;
            rd(1'b0, v);
            if (v != prev || c > 3000) break;
        end
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(1'b0, v); chk("R1 count", v, 8'h00);
        rd(1'b1, v); chk("R1 ctrl", v, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_base_rate;
        int c;
        wr(1'b0, 8'hF0);
        wait_change(c);
        wait_change(c); chk_rng("R2 select0 interval", c, 4, 4);
        wait_change(c); chk_rng("R2 select0 interval", c, 4, 4);
    endtask

    task automatic t_rates;
        int c;
        wr(1'b1, 8'h01); wr(1'b0, 8'hF0);
        wait_change(c); wait_change(c); chk_rng("R3 select1 interval", c, 8, 8);
        wr(1'b1, 8'h03);
        wait_change(c); wait_change(c); chk_rng("R3 select3 interval", c, 32, 32);
        wr(1'b1, 8'h05);
        wait_change(c); wait_change(c); chk_rng("R3 select5 interval", c, 128, 128);
    endtask

    task automatic t_preset;
        int c;
        logic [7:0] v;
        wr(1'b0, 8'hE0);
        wr(1'b1, 8'h0B);
        rd(1'b1, v); chk("R9 preset bit reads 0", v, 8'h03);
        wait_change(c); chk_rng("R9 first step after preset", c, 17, 20);
    endtask

    task automatic t_rw_wrap;
        int c;
        logic [7:0] v;
        wr(1'b1, 8'h0F);
        wr(1'b0, 8'h5A); rd(1'b0, v); chk("R4 readback", v, 8'h5A);
        wr(1'b0, 8'hA5); rd(1'b0, v); chk("R4 readback", v, 8'hA5);
        wr(1'b1, 8'h00); wr(1'b0, 8'h01);
        wait_change(c);
        rd(1'b0, v); chk("R5 count at zero", v, 8'h00);
        rd(1'b1, v); chk("R5 flag set", v, 8'h80);
        chk("R6 irq unmasked", {7'b0, irq}, 8'h01);
        wr(1'b1, 8'h00);
        wait_change(c);
        rd(1'b0, v); chk("R4 wrap to FF", v, 8'hFF);
        rd(1'b1, v); chk("R4 wrap sets no flag", v, 8'h00);
        chk("R4 wrap raises no irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_flag_irq;
        int c;
        logic [7:0] v;
        wr(1'b1, 8'h00); wr(1'b0, 8'h02);
        wait_change(c); wait_change(c);
        rd(1'b1, v); chk("R5 flag set", v, 8'h80);
        repeat (20) @(negedge clk);
        chk("R10 irq held", {7'b0, irq}, 8'h01);
        rd(1'b1, v); chk("R5 flag sticky", v[7:0] & 8'h80, 8'h80);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        chk("R10 ack clears irq", {7'b0, irq}, 8'h00);
        rd(1'b1, v); chk("R10 ack keeps flag", v, 8'h80);
        wr(1'b1, 8'h80);
        chk("R7 write 10 pends irq", {7'b0, irq}, 8'h01);
        wr(1'b1, 8'hC0);
        chk("R7 write 11 clears irq", {7'b0, irq}, 8'h00);
        rd(1'b1, v); chk("R7 ctrl readback", v, 8'hC0);
        wr(1'b1, 8'h40);
        rd(1'b1, v); chk("R8 write 0 clears flag", v, 8'h40);
        wr(1'b1, 8'h80);
        rd(1'b1, v); chk("R8 write 1 does not set", v, 8'h00);
        chk("R8 no irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_mask;
        int c;
        logic [7:0] v;
        wr(1'b1, 8'h40); wr(1'b0, 8'h02);
        wait_change(c); wait_change(c);
        rd(1'b1, v); chk("R6 masked flag set", v, 8'hC0);
        chk("R6 masked irq low", {7'b0, irq}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_base_rate();
        t_rates();
        t_preset();
        t_rw_wrap();
        t_flag_irq();
        t_mask();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule